// File: doc/BRIEF.md
# Lockable Security Control Register

This block holds one 32-bit control word whose security-related fields can be frozen one group at a time. A companion lock register gathers sticky protection bits. Software sets a lock bit by writing a 1 to it, and only a reset clears it again. While a group's lock bit is set, writes to the control word leave that group's bits unchanged. All other writable bits still take the written data.

A third address accepts an unlock key. Writing the correct 32-bit key has no effect. Writing any other value actively clears the configuration-port enable bit and the three-bit cipher-enable field, even if those bits are locked. A one-cycle warning pulse marks a control write that leaves the cipher-enable field in an inconsistent state, meaning one that is neither all zeros nor all ones.

The register bus is word-wide: address, write enable, write data and a combinational read data path. Every write takes effect on the rising clock edge at which the write enable is sampled high.

Top module: `seclock_regblock`

## Requirements
- R1: After reset the control word is 0x0C006000 (bits 27, 26, 14 and 13 set), the lock register is 0 and the warning output is low.
- R2: A write with bus_addr = 0 updates the control word at the next clock edge. Every bit in mask 0x107F6000 keeps its reset value. Every other bit outside locked groups takes the written data.
- R3: A write with bus_addr = 1 ORs write-data bits 4:0 into the lock register. Lock bits never clear before reset, write-data bits above 4 are ignored, and lock bits above 4 read as zero.
- R4: While lock bit 0 is set, control bits 6:0 (the debug group) keep their value on a control write.
- R5: While lock bit 1 is set, control bit 7 keeps its value on a control write. While lock bit 2 is set, control bit 8 keeps its value on a control write.
- R6: While lock bit 3 is set, the cipher-enable field at control bits 11:9 keeps its value on a control write. While lock bit 4 is set, control bit 12 keeps its value on a control write.
- R7: A write with bus_addr = 2 compares the data with 0x757BDF0D. A match changes nothing. Any other value clears control bit 27 and bits 11:9 at the next edge, whatever the locks, and leaves all other bits unchanged.
- R8: aes_warn is high for exactly the one cycle after a control write that leaves bits 11:9 at a value other than 000 or 111. At all other times it is low.
- R9: bus_rdata combinationally returns the control word for address 0 and the lock register (zero-extended) for address 1. It returns zero for address 2 (write-only key) and for address 3.
- R10: A write to address 3, or any cycle with bus_we low, changes neither the control word nor the lock register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W (2) | Word address: 0 control, 1 lock, 2 unlock key |
| bus_we | input | 1 | Write enable |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| ctrl_out | output | 32 | Current control word |
| lock_out | output | N_GROUPS (5) | Current lock bits |
| aes_warn | output | 1 | One-cycle pulse on an inconsistent cipher-enable write |

## Verification
The assertions check several properties on every cycle:
- lock bits never fall;
- read-only bits never move;
- a locked group holds its bits across any cycle without a bad key;
- a bad key leaves bit 27 and the cipher field at zero;
- the warning pulse only follows a control write and only with an inconsistent field;
- an idle bus changes nothing.

Only the bench scenarios can show the exact values that unlocked bits take. They also show that the correct key is harmless, that a bad key overrides a lock, and that a second reset clears the sticky locks.

// File: rtl/seclock_pkg.sv
package seclock_pkg;

    localparam int unsigned WORD_W   = 32;
    localparam int unsigned N_GROUPS = 5;
    localparam int unsigned AES_LSB  = 9;
    localparam int unsigned AES_W    = 3;

    // Reset image: configuration-port enable, port mode and two fixed bits.
    localparam logic [WORD_W-1:0] CTRL_RESET = 32'h0C00_6000;
    // Bits that no write can change.
    localparam logic [WORD_W-1:0] CTRL_RO    = 32'h107F_6000;
    // Bits cleared by a bad unlock key: port enable and cipher-enable field.
    localparam logic [WORD_W-1:0] KEY_CLEAR  = 32'h0800_0E00;

    // Control bits frozen by each lock bit.
    function automatic logic [WORD_W-1:0] group_mask(input int unsigned g);
        case (g)
            0:       group_mask = 32'h0000_007F;
            1:       group_mask = 32'h0000_0080;
            2:       group_mask = 32'h0000_0100;
            3:       group_mask = 32'h0000_0E00;
            4:       group_mask = 32'h0000_1000;
            default: group_mask = '0;
        endcase
    endfunction

    typedef struct packed {
        logic [WORD_W-1:0] ctrl;
        logic              warn;
    } ctrl_state_t;

endpackage

// File: rtl/seclock_lock.sv
module seclock_lock #(
    parameter int unsigned N_GROUPS = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [N_GROUPS-1:0] wr_bits,
    output logic [N_GROUPS-1:0] lock_q
);

    logic [N_GROUPS-1:0] lock_d;

    always_comb begin
        lock_d = lock_q;
        if (wr_en) begin
            lock_d = lock_q | wr_bits;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lock_q <= '0;
        end else begin
            lock_q <= lock_d;
        end
    end

    // R3: no lock bit ever falls while out of reset
    p_lock_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((lock_q & $past(lock_q)) == $past(lock_q)));

endmodule

// File: rtl/seclock_merge.sv
module seclock_merge
    import seclock_pkg::*;
#(
    parameter int unsigned N_GROUPS = 5
) (
    input  logic [WORD_W-1:0]   cur,
    input  logic [WORD_W-1:0]   wdata,
    input  logic [N_GROUPS-1:0] lock,
    output logic [WORD_W-1:0]   nxt
);

    logic [N_GROUPS-1:0][WORD_W-1:0] part;
    logic [WORD_W-1:0]               keep;

    for (genvar g = 0; g < N_GROUPS; g++) begin : g_grp
        assign part[g] = lock[g] ? group_mask(g) : '0;
    end

    always_comb begin
        keep = CTRL_RO;
        for (int i = 0; i < N_GROUPS; i++) begin
            keep = keep | part[i];
        end
        nxt = (cur & keep) | (wdata & ~keep);
    end

endmodule

// File: rtl/seclock_key.sv
module seclock_key
    import seclock_pkg::*;
#(
    parameter logic [WORD_W-1:0] UNLOCK_KEY = 32'h757B_DF0D
) (
    input  logic              key_we,
    input  logic [WORD_W-1:0] wdata,
    output logic              key_bad
);

    always_comb begin
        key_bad = key_we && (wdata != UNLOCK_KEY);
    end

endmodule

// File: rtl/seclock_regblock.sv
module seclock_regblock
    import seclock_pkg::*;
#(
    parameter int unsigned       ADDR_W     = 2,
    parameter logic [ADDR_W-1:0] ADDR_CTRL  = 2'd0,
    parameter logic [ADDR_W-1:0] ADDR_LOCK  = 2'd1,
    parameter logic [ADDR_W-1:0] ADDR_KEY   = 2'd2,
    parameter logic [WORD_W-1:0] UNLOCK_KEY = 32'h757B_DF0D
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_we,
    input  logic [WORD_W-1:0]   bus_wdata,
    output logic [WORD_W-1:0]   bus_rdata,
    output logic [WORD_W-1:0]   ctrl_out,
    output logic [N_GROUPS-1:0] lock_out,
    output logic                aes_warn
);

    ctrl_state_t       st_d, st_q;
    logic              wr_ctrl, wr_lock, wr_key;
    logic              key_bad;
    logic [WORD_W-1:0] merged;
    logic [AES_W-1:0]  aes_next;

    assign wr_ctrl = bus_we && (bus_addr == ADDR_CTRL);
    assign wr_lock = bus_we && (bus_addr == ADDR_LOCK);
    assign wr_key  = bus_we && (bus_addr == ADDR_KEY);

    seclock_lock #(.N_GROUPS(N_GROUPS)) u_lock (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_lock),
        .wr_bits (bus_wdata[N_GROUPS-1:0]),
        .lock_q  (lock_out)
    );

    seclock_merge #(.N_GROUPS(N_GROUPS)) u_merge (
        .cur   (st_q.ctrl),
        .wdata (bus_wdata),
        .lock  (lock_out),
        .nxt   (merged)
    );

    seclock_key #(.UNLOCK_KEY(UNLOCK_KEY)) u_key (
        .key_we  (wr_key),
        .wdata   (bus_wdata),
        .key_bad (key_bad)
    );

    assign aes_next = merged[AES_LSB +: AES_W];

    always_comb begin
        st_d      = st_q;
        st_d.warn = 1'b0;
        if (wr_ctrl) begin
            st_d.ctrl = merged;
            st_d.warn = (aes_next != '0) && (aes_next != '1);
        end else if (key_bad) begin
            st_d.ctrl = st_q.ctrl & ~KEY_CLEAR;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ctrl <= CTRL_RESET;
            st_q.warn <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_CTRL) begin
            bus_rdata = st_q.ctrl;
        end else if (bus_addr == ADDR_LOCK) begin
            bus_rdata[N_GROUPS-1:0] = lock_out;
        end
    end

    assign ctrl_out = st_q.ctrl;
    assign aes_warn = st_q.warn;

    // R2: read-only bits never move
    p_ro_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(st_q.ctrl & CTRL_RO));

    // R4, R5, R6: a locked group holds unless a bad key arrives
    for (genvar g = 0; g < N_GROUPS; g++) begin : g_hold
        p_group_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (lock_out[g] && !key_bad) |=>
            (((st_q.ctrl ^ $past(st_q.ctrl)) & group_mask(g)) == '0));
    end

    // R7: a bad key leaves the sensitive bits at zero
    p_bad_key_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        key_bad |=> ((st_q.ctrl & KEY_CLEAR) == '0));

    // R8: the warning follows a control write with an inconsistent field
    p_warn_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        aes_warn |-> ($past(wr_ctrl) &&
                      (ctrl_out[AES_LSB +: AES_W] != '0) &&
                      (ctrl_out[AES_LSB +: AES_W] != '1)));

    // R10: an idle bus changes no state
    p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_we |=> ($stable(st_q.ctrl) && $stable(lock_out)));

endmodule

// File: tb/seclock_regblock_test.sv
module seclock_regblock_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] ctrl_out;
    logic [4:0]  lock_out;
    logic        aes_warn;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    seclock_regblock uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .ctrl_out  (ctrl_out),
        .lock_out  (lock_out),
        .aes_warn  (aes_warn)
    );

    always #5 clk = ~clk;

    typedef struct packed {
        logic [3:0]  req;
        logic [1:0]  addr;
        logic [31:0] data;
        logic [31:0] ctrl;
        logic [4:0]  lock;
        logic        warn;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VEC [NV] = '{
        '{4'd2,  2'd0, 32'hFFFF_FFFF, 32'hEF80_FFFF, 5'h00, 1'b0}, // R2 all ones
        '{4'd2,  2'd0, 32'h0000_0000, 32'h0000_6000, 5'h00, 1'b0}, // R2 all zeros
        '{4'd8,  2'd0, 32'h0000_0200, 32'h0000_6200, 5'h00, 1'b1}, // R8 field 001
        '{4'd3,  2'd1, 32'h0000_0001, 32'h0000_6200, 5'h01, 1'b0}, // R3 set lock 0
        '{4'd4,  2'd0, 32'h0000_007F, 32'h0000_6000, 5'h01, 1'b0}, // R4 debug held
        '{4'd5,  2'd1, 32'h0000_0002, 32'h0000_6000, 5'h03, 1'b0}, // R5 lock 1
        '{4'd5,  2'd0, 32'h0800_0180, 32'h0800_6100, 5'h03, 1'b0}, // R5 bit7 held
        '{4'd3,  2'd1, 32'h0000_0000, 32'h0800_6100, 5'h03, 1'b0}, // R3 zero no clear
        '{4'd3,  2'd1, 32'hFFFF_FFF4, 32'h0800_6100, 5'h17, 1'b0}, // R3 upper ignored
        '{4'd6,  2'd0, 32'h0800_1FFF, 32'h0800_6F00, 5'h17, 1'b0}, // R6 bit12 held
        '{4'd7,  2'd2, 32'h1234_5678, 32'h0000_6100, 5'h17, 1'b0}, // R7 bad key
        '{4'd8,  2'd0, 32'h0800_0A00, 32'h0800_6B00, 5'h17, 1'b1}, // R8 field 101
        '{4'd6,  2'd1, 32'h0000_0008, 32'h0800_6B00, 5'h1F, 1'b0}, // R6 lock 3
        '{4'd7,  2'd2, 32'h757B_DF0D, 32'h0800_6B00, 5'h1F, 1'b0}, // R7 good key
        '{4'd7,  2'd2, 32'h0000_0000, 32'h0000_6100, 5'h1F, 1'b0}, // R7 overrides lock
        '{4'd6,  2'd0, 32'hFFFF_FFFF, 32'hEF80_E100, 5'h1F, 1'b0}, // R6 all locked
        '{4'd10, 2'd3, 32'hFFFF_FFFF, 32'hEF80_E100, 5'h1F, 1'b0}  // R10 spare addr
    };

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1", "ctrl during reset", ctrl_out, 32'h0C00_6000);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "ctrl after reset", ctrl_out, 32'h0C00_6000);
        chk("R1", "lock after reset", {27'd0, lock_out}, 32'h0);
        chk("R1", "warn after reset", {31'd0, aes_warn}, 32'h0);
        bus_read(2'd0, rd);
        chk("R9", "read ctrl at reset", rd, 32'h0C00_6000);
        bus_read(2'd1, rd);
        chk("R9", "read lock at reset", rd, 32'h0);
        bus_read(2'd2, rd);
        chk("R9", "read key address", rd, 32'h0);

        for (int i = 0; i < NV; i++) begin
            string tag;
            tag = $sformatf("R%0d vec%0d", VEC[i].req, i);
            bus_write(VEC[i].addr, VEC[i].data);
            chk(tag, "ctrl", ctrl_out, VEC[i].ctrl);
            chk(tag, "lock", {27'd0, lock_out}, {27'd0, VEC[i].lock});
            chk(tag, "warn", {31'd0, aes_warn}, {31'd0, VEC[i].warn});
        end

        bus_read(2'd0, rd);
        chk("R9", "read ctrl", rd, 32'hEF80_E100);
        bus_read(2'd1, rd);
        chk("R9", "read lock", rd, 32'h0000_001F);
        bus_read(2'd3, rd);
        chk("R9", "read spare address", rd, 32'h0);

        // R3 reset clears sticky locks
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R3", "lock after second reset", {27'd0, lock_out}, 32'h0);
        chk("R1", "ctrl after second reset", ctrl_out, 32'h0C00_6000);

        // R10 write enable low: data on the bus is ignored
        @(negedge clk);
        bus_addr  = 2'd0;
        bus_wdata = 32'hFFFF_FFFF;
        bus_we    = 1'b0;
        @(negedge clk);
        chk("R10", "ctrl with we low", ctrl_out, 32'h0C00_6000);
        bus_addr = 2'd1;
        @(negedge clk);
        chk("R10", "lock with we low", {27'd0, lock_out}, 32'h0);

        // R8 pulse lasts exactly one cycle
        bus_write(2'd0, 32'h0000_0400);
        chk("R8", "warn pulse high", {31'd0, aes_warn}, 32'h1);
        chk("R8", "ctrl with field 010", ctrl_out, 32'h0000_6400);
        @(negedge clk);
        chk("R8", "warn pulse ends", {31'd0, aes_warn}, 32'h0);
        bus_write(2'd0, 32'h0000_0E00);
        chk("R8", "warn low for 111", {31'd0, aes_warn}, 32'h0);

        // R7 bad key clears port enable after reset image
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        bus_write(2'd2, 32'h757B_DF0C);
        chk("R7", "bad key near match", ctrl_out, 32'h0400_6000);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule